// File: doc/BRIEF.md
# Serial Programming Entry Controller

This block sits on the host side of a four-wire serial programming link. It brings a target microcontroller into its serial programming mode. After a `start` request it holds the serial clock low and gives the target's reset line a high pulse of programmable width. It then keeps reset low for a programmable settle time and shifts out a four-byte enable instruction in SPI mode 0. Data is presented while the clock is low and the target samples it on the rising edge. The target changes its reply on the falling edge, and the host samples the reply on the rising edge.

The target confirms that the link is in step by returning the second instruction byte (0x53) while the third byte is being shifted. The controller always sends all four bytes and keeps the byte it captured during the third byte. If that byte is 0x53, the controller raises `done` and leaves reset low, so the target stays in programming mode. On a mismatch it pulses reset again and repeats the whole attempt. When the attempt limit runs out it raises `fail`. A higher-level sequencer reads the `done` and `fail` flags and decides what to do next.

Top module: `isp_entry_ctrl`

## Requirements
- R1: While `rst_n` is low and after its release, `busy`, `done`, `fail`, `tgt_sck`, `tgt_rst` and `tgt_mosi` are 0 and `echo_byte` is 0x00.
- R2: Each attempt begins with `tgt_rst` high for exactly RST_PULSE_CYCLES clock cycles. `tgt_sck` stays 0 whenever `tgt_rst` is high. A `start` pulse in idle makes `busy` rise on the next clock edge.
- R3: After `tgt_rst` falls, at least SETTLE_CYCLES clock cycles pass with `tgt_sck` low before the first rising edge of `tgt_sck`.
- R4: Within a byte, every high phase of `tgt_sck` lasts exactly CLK_HALF_PERIOD clock cycles and every low phase lasts at least that long. `tgt_mosi` does not change while `tgt_sck` is high.
- R5: Every attempt shifts out four bytes, most significant bit first, in the order OP_BYTE0, 0x53, OP_BYTE2, OP_BYTE3. All four are sent whatever the reply.
- R6: `tgt_miso` is sampled on each rising edge of `tgt_sck`. The byte received during the third byte of an attempt is presented on `echo_byte` and held until it is overwritten.
- R7: If the captured byte equals 0x53, `done` goes to 1 and `busy` to 0, and `tgt_rst` and `tgt_sck` stay 0.
- R8: If the captured byte differs from 0x53 and fewer than MAX_ATTEMPTS attempts have been made, a new reset pulse and a complete new attempt follow.
- R9: After MAX_ATTEMPTS attempts that all fail the echo check, `fail` goes to 1, `busy` to 0, and no further reset pulse is produced.
- R10: `done` and `fail` are never both 1. Each holds until the next accepted `start`, which clears both. A `start` while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to enter programming mode (accepted only when idle) |
| tgt_miso | input | 1 | Serial data from the target |
| tgt_sck | output | 1 | Serial clock to the target |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_rst | output | 1 | Target reset line, high during the reset pulse |
| busy | output | 1 | An entry sequence is in progress |
| done | output | 1 | Sticky: the target answered in step |
| fail | output | 1 | Sticky: the attempt limit ran out |
| echo_byte | output | 8 | Byte captured during the third byte of the last attempt |

## Verification
The assertions check the line-level rules on every cycle. These are the exact reset pulse width, the serial clock held low under reset, the exact high phase of the serial clock, data held stable while the clock is high, quiet lines when idle, and the exclusive, sticky flags. Only the bench's scenarios show the rest: byte order and content, the settle gap, the number of retries and the final outcome. They use a target model that drops out of step for a chosen number of attempts before it answers correctly. A start pulse issued in the middle of a run can only be judged from the pulse count the target sees.

// File: rtl/isp_entry_pkg.sv
// Shared definitions for the serial programming entry controller.
// Assumes nothing beyond a single clock domain.
package isp_entry_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PULSE,
        ST_SETTLE,
        ST_XFER,
        ST_EVAL
    } seq_state_e;

    // Second instruction byte, also the value that proves the link is in step
    localparam logic [7:0] SYNC_ECHO = 8'h53;

endpackage

// File: rtl/isp_sck_div.sv
// Serial clock divider: emits a one-cycle tick every HALF_PERIOD clocks
// while run is high, and restarts its count whenever run is low.
// Assumes HALF_PERIOD >= 2, so the serial clock period is at least four clocks.
module isp_sck_div #(
    parameter int HALF_PERIOD = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;

    logic [CW-1:0] cnt;

    // Count clock cycles inside one half period of the serial clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF_PERIOD - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == CW'(HALF_PERIOD - 1));

endmodule

// File: rtl/isp_byte_shift.sv
// Mode-0 byte shifter: load starts one byte. Ticks alternate the serial clock.
// The receive side samples on the rising edge, and the next transmit bit is
// presented on the falling edge. byte_done pulses once after the eighth
// falling edge. Assumes load arrives only while active is low.
module isp_byte_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       miso,
    output logic       active,
    output logic       sck,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);
    logic [7:0] tx_sh;
    logic [7:0] rx_sh;
    logic [2:0] bit_n;

    // Advance the serial clock and the two shift registers on each tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            sck       <= 1'b0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            bit_n     <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (load && !active) begin
                active <= 1'b1;
                tx_sh  <= tx_byte;
                bit_n  <= '0;
                sck    <= 1'b0;
            end else if (active && tick) begin
                if (!sck) begin
                    sck   <= 1'b1;
                    rx_sh <= {rx_sh[6:0], miso};
                end else begin
                    sck   <= 1'b0;
                    tx_sh <= {tx_sh[6:0], 1'b0};
                    if (bit_n == 3'd7) begin
                        active    <= 1'b0;
                        byte_done <= 1'b1;
                    end else begin
                        bit_n <= bit_n + 1'b1;
                    end
                end
            end
        end
    end

    assign mosi    = tx_sh[7];
    assign rx_byte = rx_sh;

endmodule

// File: rtl/isp_entry_seq.sv
// Attempt sequencer: reset pulse, settle wait, four-byte enable instruction,
// echo check and retry bookkeeping, with sticky done and fail flags.
// Assumes the shifter returns byte_done exactly once per load.
module isp_entry_seq
    import isp_entry_pkg::*;
#(
    parameter int         SETTLE_CYCLES    = 400000,
    parameter int         RST_PULSE_CYCLES = 8,
    parameter int         MAX_ATTEMPTS     = 4,
    parameter logic [7:0] OP_BYTE0         = 8'hAC,
    parameter logic [7:0] OP_BYTE2         = 8'h00,
    parameter logic [7:0] OP_BYTE3         = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       byte_done,
    input  logic [7:0] rx_byte,
    output logic       load,
    output logic [7:0] tx_byte,
    output logic       tgt_rst,
    output logic       busy,
    output logic       done,
    output logic       fail,
    output logic [7:0] echo_byte
);
    localparam int CMAX = (SETTLE_CYCLES > RST_PULSE_CYCLES) ? SETTLE_CYCLES : RST_PULSE_CYCLES;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int RW   = $clog2(MAX_ATTEMPTS + 1);
    localparam logic [7:0] INSTR [4] = '{OP_BYTE0, SYNC_ECHO, OP_BYTE2, OP_BYTE3};

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic [RW-1:0] tries;
    logic [1:0]    byte_idx;

    // Walk through pulse, settle, transfer and evaluation for each attempt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            tries     <= '0;
            byte_idx  <= '0;
            load      <= 1'b0;
            tgt_rst   <= 1'b0;
            done      <= 1'b0;
            fail      <= 1'b0;
            echo_byte <= '0;
        end else begin
            load <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        done    <= 1'b0;
                        fail    <= 1'b0;
                        tries   <= '0;
                        cnt     <= '0;
                        tgt_rst <= 1'b1;
                        state   <= ST_PULSE;
                    end
                end
                ST_PULSE: begin
                    if (cnt == CW'(RST_PULSE_CYCLES - 1)) begin
                        tgt_rst <= 1'b0;
                        cnt     <= '0;
                        state   <= ST_SETTLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt == CW'(SETTLE_CYCLES - 1)) begin
                        byte_idx <= '0;
                        load     <= 1'b1;
                        state    <= ST_XFER;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_XFER: begin
                    if (byte_done) begin
                        if (byte_idx == 2'd2) begin
                            echo_byte <= rx_byte;
                        end
                        if (byte_idx == 2'd3) begin
                            state <= ST_EVAL;
                        end else begin
                            byte_idx <= byte_idx + 1'b1;
                            load     <= 1'b1;
                        end
                    end
                end
                ST_EVAL: begin
                    if (echo_byte == SYNC_ECHO) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else if (tries == RW'(MAX_ATTEMPTS - 1)) begin
                        fail  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        tries   <= tries + 1'b1;
                        cnt     <= '0;
                        tgt_rst <= 1'b1;
                        state   <= ST_PULSE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_byte = INSTR[byte_idx];
    assign busy    = (state != ST_IDLE);

endmodule

// File: rtl/isp_entry_ctrl.sv
// Top level of the serial programming entry controller: connects the
// attempt sequencer, the byte shifter and the serial clock divider.
// Assumes tgt_miso is already synchronous to clk or slow relative to it.
module isp_entry_ctrl #(
    parameter int         CLK_HALF_PERIOD  = 3,
    parameter int         SETTLE_CYCLES    = 400000,
    parameter int         RST_PULSE_CYCLES = 8,
    parameter int         MAX_ATTEMPTS     = 4,
    parameter logic [7:0] OP_BYTE0         = 8'hAC,
    parameter logic [7:0] OP_BYTE2         = 8'h00,
    parameter logic [7:0] OP_BYTE3         = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       tgt_miso,
    output logic       tgt_sck,
    output logic       tgt_mosi,
    output logic       tgt_rst,
    output logic       busy,
    output logic       done,
    output logic       fail,
    output logic [7:0] echo_byte
);
    logic       load;
    logic [7:0] tx_byte;
    logic       byte_done;
    logic [7:0] rx_byte;
    logic       sh_active;
    logic       tick;

    isp_entry_seq #(
        .SETTLE_CYCLES   (SETTLE_CYCLES),
        .RST_PULSE_CYCLES(RST_PULSE_CYCLES),
        .MAX_ATTEMPTS    (MAX_ATTEMPTS),
        .OP_BYTE0        (OP_BYTE0),
        .OP_BYTE2        (OP_BYTE2),
        .OP_BYTE3        (OP_BYTE3)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .byte_done(byte_done),
        .rx_byte  (rx_byte),
        .load     (load),
        .tx_byte  (tx_byte),
        .tgt_rst  (tgt_rst),
        .busy     (busy),
        .done     (done),
        .fail     (fail),
        .echo_byte(echo_byte)
    );

    isp_byte_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .tx_byte  (tx_byte),
        .tick     (tick),
        .miso     (tgt_miso),
        .active   (sh_active),
        .sck      (tgt_sck),
        .mosi     (tgt_mosi),
        .byte_done(byte_done),
        .rx_byte  (rx_byte)
    );

    isp_sck_div #(
        .HALF_PERIOD(CLK_HALF_PERIOD)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (sh_active),
        .tick (tick)
    );

endmodule

// File: rtl/isp_entry_ctrl_chk.sv
// Property checker for isp_entry_ctrl, attached to every instance by bind.
// Assumes the same clock and synchronous active-low reset as the design.
module isp_entry_ctrl_chk #(
    parameter int HALF_PERIOD  = 3,
    parameter int PULSE_CYCLES = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tgt_sck,
    input logic tgt_mosi,
    input logic tgt_rst,
    input logic busy,
    input logic done,
    input logic fail
);
    int hi_len;
    int rst_len;

    // Length of the current high run on the serial clock and on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_len  <= 0;
            rst_len <= 0;
        end else begin
            hi_len  <= tgt_sck ? hi_len + 1 : 0;
            rst_len <= tgt_rst ? rst_len + 1 : 0;
        end
    end

    // R2
    rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_rst) |-> rst_len == PULSE_CYCLES);

    // R2
    sck_low_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_rst |-> !tgt_sck);

    // R4
    sck_high_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tgt_sck) |-> hi_len == HALF_PERIOD);

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_sck |-> $stable(tgt_mosi));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!tgt_sck && !tgt_rst));

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R10
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    // R10
    busy_flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !fail));

endmodule

bind isp_entry_ctrl isp_entry_ctrl_chk #(
    .HALF_PERIOD (CLK_HALF_PERIOD),
    .PULSE_CYCLES(RST_PULSE_CYCLES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .tgt_sck (tgt_sck),
    .tgt_mosi(tgt_mosi),
    .tgt_rst (tgt_rst),
    .busy    (busy),
    .done    (done),
    .fail    (fail)
);

// File: tb/isp_entry_ctrl_bench.sv
// Scoreboard bench: the driver queues the bytes each attempt must carry, and
// a target model pops and compares them as they arrive on the serial link.
module isp_entry_ctrl_bench;
    localparam int         HALF   = 2;
    localparam int         SETTLE = 40;
    localparam int         PULSE  = 4;
    localparam int         MAXA   = 3;
    localparam logic [7:0] OP0    = 8'hAC;
    localparam logic [7:0] OP2    = 8'h12;
    localparam logic [7:0] OP3    = 8'h34;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       tgt_miso;
    logic       tgt_sck, tgt_mosi, tgt_rst, busy, done, fail;
    logic [7:0] echo_byte;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    isp_entry_ctrl #(
        .CLK_HALF_PERIOD (HALF),
        .SETTLE_CYCLES   (SETTLE),
        .RST_PULSE_CYCLES(PULSE),
        .MAX_ATTEMPTS    (MAXA),
        .OP_BYTE0        (OP0),
        .OP_BYTE2        (OP2),
        .OP_BYTE3        (OP3)
    ) u_isp_entry_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .tgt_miso(tgt_miso),
        .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_rst(tgt_rst),
        .busy(busy), .done(done), .fail(fail), .echo_byte(echo_byte)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)",
                     req, what, act, act, exp, exp);
        end
    endtask

    // ---------------- target model ----------------
    logic [7:0] exp_q[$];
    int   pulse_count = 0;
    int   base_pulse  = 0;
    int   desync_n    = 0;
    logic [7:0] rx_sh = 8'h00;
    logic [7:0] tx_b  = 8'h00;
    int   bitc = 0;
    logic miso_r = 1'b0;

    assign tgt_miso = miso_r;

    // Reset pulse restarts the target's serial logic
    always @(posedge tgt_rst) begin
        pulse_count++;
        bitc   = 0;
        tx_b   = 8'h00;
        miso_r = 1'b0;
    end

    // Rising edge: take one bit; after eight, score the byte and load the reply
    always @(posedge tgt_sck) begin
        rx_sh = {rx_sh[6:0], tgt_mosi};
        bitc++;
        if (bitc == 8) begin
            bitc = 0;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected byte", int'(rx_sh), -1);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(rx_sh == e, "R5", "byte on MOSI", int'(rx_sh), int'(e));
            end
            tx_b   = ((pulse_count - base_pulse) <= desync_n) ? ~rx_sh : rx_sh;
            miso_r = tx_b[7];
        end
    end

    // Falling edge: present the next reply bit
    always @(negedge tgt_sck) begin
        if (bitc != 0) miso_r = tx_b[7 - bitc];
    end

    // ---------------- line timing monitor ----------------
    int rst_run = 0, rst_min = 0, rst_max = 0;
    int gap_cnt = 0, gap_min = 0;
    bit gap_on = 1'b0;
    int hi_run = 0, hi_min = 0, hi_max = 0;
    int lo_run = 0, lo_min = 0;
    bit seen_hi = 1'b0;

    task automatic clear_meas();
        rst_min = 1 << 30; rst_max = 0; gap_min = 1 << 30;
        hi_min = 1 << 30; hi_max = 0; lo_min = 1 << 30;
    endtask

    // Measure phase lengths between falling clock edges
    always @(negedge clk) begin
        if (tgt_rst) begin
            rst_run++;
            seen_hi = 1'b0;
            lo_run  = 0;
        end else if (rst_run > 0) begin
            if (rst_run < rst_min) rst_min = rst_run;
            if (rst_run > rst_max) rst_max = rst_run;
            rst_run = 0;
            gap_on  = 1'b1;
            gap_cnt = 0;
        end
        if (gap_on && !tgt_rst) begin
            if (tgt_sck) begin
                if (gap_cnt < gap_min) gap_min = gap_cnt;
                gap_on = 1'b0;
            end else begin
                gap_cnt++;
            end
        end
        if (tgt_sck) begin
            if (seen_hi && lo_run > 0 && lo_run < lo_min) lo_min = lo_run;
            lo_run = 0;
            hi_run++;
            seen_hi = 1'b1;
        end else begin
            if (hi_run > 0) begin
                if (hi_run < hi_min) hi_min = hi_run;
                if (hi_run > hi_max) hi_max = hi_run;
            end
            hi_run = 0;
            if (!tgt_rst) lo_run++;
        end
    end

    // ---------------- driver ----------------
    task automatic run_session(input int desync, input int attempts, input bit exp_done,
                               input logic [7:0] exp_echo, input bit poke_busy);
        int waited;
        base_pulse = pulse_count;
        desync_n   = desync;
        clear_meas();
        for (int a = 0; a < attempts; a++) begin
            exp_q.push_back(OP0);
            exp_q.push_back(8'h53);
            exp_q.push_back(OP2);
            exp_q.push_back(OP3);
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        check(done == 1'b0 && fail == 1'b0, "R10", "flags cleared by start",
              int'({done, fail}), 0);
        if (poke_busy) begin
            repeat (PULSE + SETTLE + 20) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        waited = 0;
        while (busy && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(!busy, "R9", "sequence ends (watchdog)", int'(busy), 0);
        check(done == exp_done, "R7", "done flag", int'(done), int'(exp_done));
        check(fail == !exp_done, "R9", "fail flag", int'(fail), int'(!exp_done));
        check(echo_byte == exp_echo, "R6", "captured echo", int'(echo_byte), int'(exp_echo));
        check(pulse_count - base_pulse == attempts, "R8", "reset pulses",
              pulse_count - base_pulse, attempts);
        check(exp_q.size() == 0, "R5", "bytes left unsent", exp_q.size(), 0);
        check(rst_min == PULSE && rst_max == PULSE, "R2", "reset pulse width",
              rst_max, PULSE);
        check(gap_min >= SETTLE, "R3", "settle gap", gap_min, SETTLE);
        check(hi_min == HALF && hi_max == HALF, "R4", "SCK high phase", hi_max, HALF);
        check(lo_min >= HALF, "R4", "SCK low phase", lo_min, HALF);
        repeat (20) @(negedge clk);
        check(done == exp_done && fail == !exp_done, "R10", "flags held in idle",
              int'({done, fail}), int'({exp_done, !exp_done}));
        check(pulse_count - base_pulse == attempts && !tgt_rst && !tgt_sck, "R9",
              "no activity after finish", pulse_count - base_pulse, attempts);
        if (exp_done) exp_q.delete();
    endtask

    // Global watchdog: counts as a failed check and still reports
    initial begin
        #(200000 * 4);
        check(1'b0, "R1", "global watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state held under reset
        check({busy, done, fail, tgt_sck, tgt_rst, tgt_mosi} == 6'b0, "R1",
              "outputs in reset", int'({busy, done, fail, tgt_sck, tgt_rst, tgt_mosi}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({busy, done, fail, tgt_sck, tgt_rst, tgt_mosi} == 6'b0 && echo_byte == 8'h00,
              "R1", "outputs after reset", int'({busy, done, fail, tgt_sck, tgt_rst}), 0);

        // R7: target in step on the first attempt
        run_session(0, 1, 1'b1, 8'h53, 1'b0);
        // R8: two bad attempts then success, start pulsed mid-run must be ignored (R10)
        run_session(2, 3, 1'b1, 8'h53, 1'b1);
        // R9: never in step, limit reached
        run_session(5, MAXA, 1'b0, 8'hAC, 1'b0);
        // R8 / R10: one bad attempt, start clears the earlier fail
        run_session(1, 2, 1'b1, 8'h53, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule